// File: doc/BRIEF.md
# Bi-phase Level Line Encoder

This block turns a serial bit stream and its bit clock into a single self-clocking line signal, one symbol per clock period. The data input is captured on every rising clock edge. The bit cell for that value starts at the same edge and fills the full clock period. The first half of the cell follows the clock-high phase and the second half follows the clock-low phase, so both clock edges shape the line.

A one is sent as a high first half followed by a low second half. A zero is sent as a low first half followed by a high second half. Every cell therefore has a transition at its middle. A transition at a cell boundary appears only when two consecutive bits are equal. The line is driven on a true output and on its complement, so it can feed a differential driver.

The output is formed from a pair of flip-flops, one clocked on each clock edge, combined through an XOR. Only one of the two flip-flops changes at any edge, so the line never glitches when the data register updates. The reset is synchronous and active-high. It parks the line low.

Top module: `mce_encoder`

## Requirements
- R1: When the captured bit is 1, `tx` is high from the rising edge that captured it until the following falling edge, and low from that falling edge until the next rising edge (a falling transition at mid-cell).
- R2: When the captured bit is 0, `tx` is low during the clock-high phase of its cell and high during the clock-low phase (a rising transition at mid-cell).
- R3: `din` is sampled on each rising edge of `clk` and sets the polarity of the cell starting at that edge; every clock period carries exactly one bit.
- R4: `tx` changes at a cell boundary (a rising edge) if and only if the bit of the new cell equals the bit of the previous cell.
- R5: `tx_n` is always the logical complement of `tx` once reset has been applied.
- R6: Once `rst` has been high at two consecutive rising edges, `tx` is low and `tx_n` is high at that edge and for as long as `rst` stays high, whatever `din` does.
- R7: The first cell after reset is released starts at the first rising edge at which `rst` is low, and carries the `din` value sampled there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; its frequency equals the line baud rate |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, sampled on the rising edge of `clk` |
| tx | output | 1 | Encoded line signal |
| tx_n | output | 1 | Complement of `tx` |

## Verification
The block has no size parameters, so the bench builds it as it stands and runs it at the top rate, one bit per 20-unit clock period. Each cell is sampled once in its high phase and once in its low phase. This is enough to check the mid-cell direction of every bit, the boundary transitions between neighbouring bits and the complement on both phases. Long runs of ones and of zeros, strict alternation and a pseudo-random stream cover every pair of neighbouring bits. Reset is applied between streams, with `din` toggling while it is held.

// File: rtl/mce_pkg.sv
package mce_pkg;

  // Level that a cell carrying bit_v presents in a given half.
  // late = 0: clock-high half, late = 1: clock-low half.
  function automatic logic half_level(input logic bit_v, input logic late);
    return late ? ~bit_v : bit_v;
  endfunction

endpackage

// File: rtl/mce_sampler.sv
module mce_sampler (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic bit_q,
  output logic run_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      bit_q <= din;
      run_q <= 1'b1;
    end
  end

endmodule

// File: rtl/mce_rise_half.sv
// Rising-edge half of the XOR flop pair: sets the line to the early-half level.
module mce_rise_half
  import mce_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic fall_q,
  output logic rise_q
);

  always_ff @(posedge clk) begin
    if (rst) rise_q <= 1'b0;
    else     rise_q <= half_level(din, 1'b0) ^ fall_q;
  end

endmodule

// File: rtl/mce_fall_half.sv
// Falling-edge half of the XOR flop pair: sets the line to the late-half level.
module mce_fall_half
  import mce_pkg::*;
(
  input  logic clk,
  input  logic run,
  input  logic bit_q,
  input  logic rise_q,
  output logic fall_q
);

  always_ff @(negedge clk) begin
    if (!run) fall_q <= 1'b0;
    else      fall_q <= half_level(bit_q, 1'b1) ^ rise_q;
  end

endmodule

// File: rtl/mce_encoder.sv
module mce_encoder (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic tx,
  output logic tx_n
);

  logic bit_q;
  logic run_q;
  logic rise_q;
  logic fall_q;

  mce_sampler u_sampler (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .bit_q (bit_q),
    .run_q (run_q)
  );

  mce_rise_half u_rise (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .fall_q (fall_q),
    .rise_q (rise_q)
  );

  mce_fall_half u_fall (
    .clk    (clk),
    .run    (run_q),
    .bit_q  (bit_q),
    .rise_q (rise_q),
    .fall_q (fall_q)
  );

  // Only one flop of the pair toggles per edge, so the XOR cannot glitch.
  assign tx   = rise_q ^ fall_q;
  assign tx_n = ~(rise_q ^ fall_q);

endmodule

// File: rtl/mce_encoder_checker.sv
module mce_encoder_checker (
  input logic clk,
  input logic rst,
  input logic din,
  input logic tx,
  input logic tx_n
);

  logic live  = 1'b0;
  logic cap   = 1'b0;
  logic rst_d = 1'b0;

  always_ff @(posedge clk) begin
    live  <= !rst;
    cap   <= din;
    rst_d <= rst;
  end

  // R1 / R2 / R3 / R7: clock-high half carries the bit captured at the last rising edge
  a_r1_first_half: assert property (@(negedge clk) disable iff (rst)
    live |-> (tx == cap));

  // R1 / R2: clock-low half carries the inverse of that bit
  a_r2_second_half: assert property (@(posedge clk) disable iff (rst)
    live |-> (tx == !cap));

  // R5: complement on both phases
  a_r5_comp_rise: assert property (@(posedge clk) disable iff (rst)
    live |-> (tx_n == !tx));
  a_r5_comp_fall: assert property (@(negedge clk) disable iff (rst)
    live |-> (tx_n == !tx));

  // R6: line parked low after two reset edges
  a_r6_reset_park: assert property (@(posedge clk)
    (rst && rst_d) |-> (!tx && tx_n));

endmodule

bind mce_encoder mce_encoder_checker u_mce_encoder_checker (
  .clk  (clk),
  .rst  (rst),
  .din  (din),
  .tx   (tx),
  .tx_n (tx_n)
);

// File: tb/mce_encoder_bench.sv
module mce_encoder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic tx;
  logic tx_n;

  int n_run  = 0;
  int n_fail = 0;
  logic exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  mce_encoder u_mce_encoder (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .tx   (tx),
    .tx_n (tx_n)
  );

  task automatic check(input logic ok, input string req, input logic act, input logic exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected bit per cell and checks both halves.
  initial begin
    logic b;
    logic prev_b;
    logic prev_valid;
    logic first;
    prev_valid = 1'b0;
    prev_b = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        b = exp_q.pop_front();
        first = tx;
        if (!prev_valid)
          check(first == b, "R7 first cell after reset", first, b);
        else if (b)
          check(first == 1'b1, "R1 one first half high", first, 1'b1);
        else
          check(first == 1'b0, "R2 zero first half low", first, 1'b0);
        check(tx_n == !tx, "R5 complement high phase", tx_n, !tx);
        if (prev_valid)
          check((first != !prev_b) == (b == prev_b), "R4 boundary transition",
                first != !prev_b, b == prev_b);
        @(negedge clk); #1;
        check(tx == !b, b ? "R1 one second half low" : "R2 zero second half high", tx, !b);
        check(tx != first, "R3 one mid-cell transition per period", tx, !first);
        check(tx_n == !tx, "R5 complement low phase", tx_n, !tx);
        prev_b = b;
        prev_valid = 1'b1;
      end else begin
        prev_valid = 1'b0;
      end
    end
  end

  task automatic send(input logic b);
    @(posedge clk); #2;
    rst = 1'b0;
    din = b;
    exp_q.push_back(b);
  endtask

  task automatic drain();
    @(posedge clk); #2;
    @(posedge clk); #2;
  endtask

  task automatic reset_hold(input int cycles);
    @(posedge clk); #2;
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (i >= 1) begin
        check(tx == 1'b0, "R6 tx low in reset", tx, 1'b0);
        check(tx_n == 1'b1, "R6 tx_n high in reset", tx_n, 1'b1);
      end
      #1 din = ~din;
      @(negedge clk); #1;
      if (i >= 1) check(tx == 1'b0, "R6 tx low in reset, low phase", tx, 1'b0);
    end
  endtask

  initial begin
    reset_hold(4);
    for (int i = 0; i < 16; i++) send(1'b1);
    for (int i = 0; i < 16; i++) send(1'b0);
    for (int i = 0; i < 16; i++) send(i[0]);
    drain();
    reset_hold(3);
    send(1'b0);
    send(1'b0);
    send(1'b1);
    drain();
    reset_hold(3);
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      // Bias toward repeats to make long runs of identical bits
      send((i % 7 < 3) ? lfsr[0] : din);
    end
    drain();
    reset_hold(3);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule